// File: doc/BRIEF.md
# 64-bit Shift and Rotate Unit

This block is the shifter of a 64-bit integer datapath. It takes one operand and moves its bits left or right, with zero fill, sign fill or wrap-around. A 4-bit operation select picks the direction and fill, and also where the shift distance comes from. The distance can be a 5-bit immediate (0 to 31), the same immediate with 32 added (32 to 63), or the low six bits of a second register operand.

The shifting logic is a log2(width)-stage barrel network with no internal state. A parameter adds an output register, which gives the result one cycle of latency and a known reset value. Decoding of the instruction and access to the register file are done by the pipeline around the unit.

Top module: `shift64_unit`

## Requirements
- R1: Operation select bits [1:0] choose the kind (0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right). A logical left shift by n fills the low n positions with zeros.
- R2: A logical right shift by n fills the top n positions with zeros.
- R3: An arithmetic right shift by n fills the top n positions with copies of operand bit 63.
- R4: A rotate right by a nonzero n returns (operand >> n) | (operand << (64 - n)).
- R5: When select bits [3:2] are 0 (immediate form), the distance is `imm_amt`, which ranges from 0 to 31.
- R6: When select bits [3:2] are 1 (immediate-plus-32 form), the distance is `imm_amt` + 32, which ranges from 32 to 63.
- R7: When select bits [3:2] are 2 (variable form), the distance is `amt_reg[5:0]`, and bits [63:6] of `amt_reg` have no effect on the result.
- R8: A rotate whose effective distance is zero returns the operand unchanged.
- R9: Select codes 12 to 15 (bits [3:2] equal to 3) produce an all-zero result.
- R10: With `REG_OUT`=1 (the default), the result appears on the clock edge after the inputs are applied. While `rst_n` is low the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 4 | Operation select: bits [3:2] form, bits [1:0] kind |
| operand | input | 64 | Value to be shifted or rotated |
| imm_amt | input | 5 | Immediate distance field |
| amt_reg | input | 64 | Register operand; only bits [5:0] are used as the distance |
| result | output | 64 | Shifted or rotated value |

## Verification
The checker assumes that the inputs are steady around each rising clock edge. It relates each result to the select, operand and distance that were sampled one edge earlier, and it starts from an unused select code after reset, because the output register resets to zero. The bench changes inputs only on falling edges. It holds one set of inputs per cycle and queues the expected value computed from the rules above. This keeps the checker's one-edge alignment true for every vector: directed corner cases and a deterministic pseudo-random sweep over all sixteen select codes.

// File: rtl/shift64_pkg.sv
package shift64_pkg;

   localparam int OP_W = 4;

   typedef enum logic [1:0] {
      K_SLL = 2'd0,
      K_SRL = 2'd1,
      K_SRA = 2'd2,
      K_ROR = 2'd3
   } sh_kind_e;

   typedef enum logic [1:0] {
      F_IMM   = 2'd0,
      F_IMM32 = 2'd1,
      F_VAR   = 2'd2,
      F_NONE  = 2'd3
   } sh_form_e;

   typedef struct packed {
      logic     vld;
      sh_kind_e kind;
   } sh_ctl_t;

endpackage

// File: rtl/shift64_amount.sv
module shift64_amount
   import shift64_pkg::*;
#(
   parameter int W = 64
) (
   input  logic [OP_W-1:0]       op_sel,
   input  logic [$clog2(W)-2:0]  imm_amt,
   input  logic [W-1:0]          amt_reg,
   output logic [$clog2(W)-1:0]  amt,
   output sh_ctl_t               ctl
);
   localparam int AW = $clog2(W);

   sh_form_e form;
   logic     unused_hi;

   assign form      = sh_form_e'(op_sel[3:2]);
   assign unused_hi = ^amt_reg[W-1:AW];

   always_comb begin
      ctl.kind = sh_kind_e'(op_sel[1:0]);
      ctl.vld  = 1'b1;
      unique case (form)
         F_IMM:   amt = {1'b0, imm_amt};
         F_IMM32: amt = {1'b1, imm_amt};
         F_VAR:   amt = amt_reg[AW-1:0];
         default: begin
            amt     = '0;
            ctl.vld = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/shift64_core.sv
module shift64_core
   import shift64_pkg::*;
#(
   parameter int W = 64
) (
   input  logic [W-1:0]         din,
   input  sh_kind_e             kind,
   input  logic [$clog2(W)-1:0] amt,
   output logic [W-1:0]         dout
);
   localparam int STAGES = $clog2(W);

   logic [STAGES:0][W-1:0] stage;
   logic                   sign;

   function automatic logic [W-1:0] step(input logic [W-1:0] x,
                                         input sh_kind_e kind_i,
                                         input logic fill,
                                         input int sh);
      logic [W-1:0] hi_mask;
      hi_mask = ~({W{1'b1}} >> sh);
      unique case (kind_i)
         K_SLL:   step = x << sh;
         K_SRL:   step = x >> sh;
         K_SRA:   step = (x >> sh) | (hi_mask & {W{fill}});
         default: step = (x >> sh) | (x << (W - sh));
      endcase
   endfunction

   assign sign     = din[W-1];
   assign stage[0] = din;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      localparam int SH = 1 << g;
      assign stage[g+1] = amt[g] ? step(stage[g], kind, sign, SH) : stage[g];
   end

   assign dout = stage[STAGES];

endmodule

// File: rtl/shift64_unit.sv
module shift64_unit
   import shift64_pkg::*;
#(
   parameter int W       = 64,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [OP_W-1:0]      op_sel,
   input  logic [W-1:0]         operand,
   input  logic [$clog2(W)-2:0] imm_amt,
   input  logic [W-1:0]         amt_reg,
   output logic [W-1:0]         result
);
   localparam int AW = $clog2(W);

   if (W < 8 || (W & (W - 1)) != 0) begin : g_bad_width
      $error("shift64_unit: W must be a power of two and at least 8");
   end

   logic [AW-1:0] amt;
   sh_ctl_t       ctl;
   logic [W-1:0]  shifted;
   logic [W-1:0]  res_c;

   shift64_amount #(.W(W)) u_amount (
      .op_sel  (op_sel),
      .imm_amt (imm_amt),
      .amt_reg (amt_reg),
      .amt     (amt),
      .ctl     (ctl)
   );

   shift64_core #(.W(W)) u_core (
      .din  (operand),
      .kind (ctl.kind),
      .amt  (amt),
      .dout (shifted)
   );

   assign res_c = ctl.vld ? shifted : '0;

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) result <= '0;
         else        result <= res_c;
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign result     = res_c;
   end

endmodule

// File: rtl/shift64_chk.sv
module shift64_chk
   import shift64_pkg::*;
#(
   parameter int W       = 64,
   parameter bit REG_OUT = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [OP_W-1:0]      op_sel,
   input logic [W-1:0]         operand,
   input logic [$clog2(W)-2:0] imm_amt,
   input logic [W-1:0]         amt_reg,
   input logic [W-1:0]         result
);
   localparam int AW = $clog2(W);

   logic [OP_W-1:0] d_op;
   logic [W-1:0]    d_x;
   logic [AW-1:0]   d_ramt;
   logic            unused_chk;

   assign unused_chk = ^{imm_amt, amt_reg[W-1:AW]};

   if (REG_OUT) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            d_op   <= 4'hF;
            d_x    <= '0;
            d_ramt <= '0;
         end else begin
            d_op   <= op_sel;
            d_x    <= operand;
            d_ramt <= amt_reg[AW-1:0];
         end
      end
   end else begin : g_now
      assign d_op   = op_sel;
      assign d_x    = operand;
      assign d_ramt = amt_reg[AW-1:0];
   end

   // R9
   unused_code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      d_op[3:2] == 2'b11 |-> result == '0);

   // R8
   rot_zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (d_op == {F_VAR, K_ROR} && d_ramt == '0) |-> result == d_x);

   // R6
   sll32_low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      d_op == {F_IMM32, K_SLL} |-> result[W/2-1:0] == '0);

   // R2
   srl32_high_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      d_op == {F_IMM32, K_SRL} |-> result[W-1:W/2] == '0);

   // R3
   sra_sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (d_op[1:0] == K_SRA && d_op[3:2] != F_NONE) |-> result[W-1] == d_x[W-1]);

   // R4
   rot_popcount_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (d_op[1:0] == K_ROR && d_op[3:2] != F_NONE) |->
         $countones(result) == $countones(d_x));

endmodule

bind shift64_unit shift64_chk #(.W(W), .REG_OUT(REG_OUT)) u_shift64_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .op_sel  (op_sel),
   .operand (operand),
   .imm_amt (imm_amt),
   .amt_reg (amt_reg),
   .result  (result)
);

// File: tb/test_shift64_unit.sv
module test_shift64_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op_sel = 4'h0;
   logic [63:0] operand = '0;
   logic [4:0]  imm_amt = '0;
   logic [63:0] amt_reg = '0;
   logic [63:0] result;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   typedef struct {
      logic [63:0] exp;
      string       req;
      logic [3:0]  op;
   } item_t;

   item_t sb_q[$];

   always #10 clk = ~clk;

   shift64_unit i_shift64_unit (
      .clk     (clk),
      .rst_n   (rst_n),
      .op_sel  (op_sel),
      .operand (operand),
      .imm_amt (imm_amt),
      .amt_reg (amt_reg),
      .result  (result)
   );

   function automatic logic [63:0] model(logic [3:0] op, logic [63:0] x,
                                         logic [4:0] imm, logic [63:0] r);
      int n;
      case (op[3:2])
         2'd0:    n = int'(imm);
         2'd1:    n = int'(imm) + 32;
         2'd2:    n = int'(r[5:0]);
         default: return 64'd0;
      endcase
      case (op[1:0])
         2'd0:    return x << n;
         2'd1:    return x >> n;
         2'd2:    return 64'($signed(x) >>> n);
         default: return (n == 0) ? x : ((x >> n) | (x << (64 - n)));
      endcase
   endfunction

   function automatic string tag_of(logic [3:0] op);
      string k, f;
      if (op[3:2] == 2'd3) return "R9";
      case (op[1:0])
         2'd0: k = "R1";
         2'd1: k = "R2";
         2'd2: k = "R3";
         default: k = "R4";
      endcase
      case (op[3:2])
         2'd0: f = "R5";
         2'd1: f = "R6";
         default: f = "R7";
      endcase
      return {k, "/", f};
   endfunction

   task automatic drive(logic [3:0] op, logic [63:0] x, logic [4:0] imm,
                        logic [63:0] r, string req);
      item_t it;
      @(negedge clk);
      op_sel  = op;
      operand = x;
      imm_amt = imm;
      amt_reg = r;
      it.exp  = model(op, x, imm, r);
      it.req  = (req == "") ? tag_of(op) : req;
      it.op   = op;
      sb_q.push_back(it);
   endtask

   // scoreboard monitor: result for inputs applied at a falling edge is valid after the next rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (rst_n && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_tests++;
            if (result !== it.exp) begin
               n_fail++;
               $display("FAIL %s op=%0h actual=%h expected=%h", it.req, it.op, result, it.exp);
            end
         end
      end
   end

   initial begin
      logic [63:0] s;
      s = 64'h9E37_79B9_7F4A_7C15;

      // R10: reset state, with a valid operation on the inputs
      op_sel  = 4'h0;
      operand = 64'hFFFF_FFFF_FFFF_FFFF;
      imm_amt = 5'd3;
      repeat (3) @(posedge clk);
      #1;
      n_tests++;
      if (result !== 64'd0) begin
         n_fail++;
         $display("FAIL R10 reset actual=%h expected=%h", result, 64'd0);
      end
      @(negedge clk);
      rst_n = 1'b1;

      // R1 / R5: immediate boundaries 0 and 31
      drive(4'h0, 64'h8000_0000_0000_0001, 5'd0,  '0, "R1/R5");
      drive(4'h0, 64'h8000_0000_0000_0001, 5'd31, '0, "R1/R5");
      // R6: plus-32 boundaries 32 and 63
      drive(4'h4, 64'h0000_0000_0000_0003, 5'd0,  '0, "R1/R6");
      drive(4'h5, 64'h8000_0000_0000_0000, 5'd31, '0, "R2/R6");
      // R3: sign fill, negative and positive
      drive(4'h6, 64'h8000_0000_0000_0000, 5'd31, '0, "R3/R6");
      drive(4'h2, 64'h7FF0_0000_0000_0000, 5'd4,  '0, "R3/R5");
      drive(4'hA, 64'hF000_0000_0000_00F0, 5'd0,  64'd63, "R3/R7");
      // R4: rotate wrap-around
      drive(4'h3, 64'h0123_4567_89AB_CDEF, 5'd4,  '0, "R4/R5");
      drive(4'h7, 64'h0123_4567_89AB_CDEF, 5'd31, '0, "R4/R6");
      // R8: rotate by zero, immediate and variable
      drive(4'h3, 64'hDEAD_BEEF_0BAD_F00D, 5'd0, '0, "R8");
      drive(4'hB, 64'hDEAD_BEEF_0BAD_F00D, 5'd7, 64'd64, "R8");
      // R7: high bits of the register operand are ignored
      drive(4'h8, 64'h0000_0000_0000_00FF, 5'd0, 64'hFFFF_FFFF_FFFF_FF04, "R7");
      drive(4'h9, 64'hFFFF_0000_0000_0000, 5'd0, 64'h8000_0000_0000_0010, "R7");
      drive(4'hB, 64'h0000_0000_0000_0001, 5'd0, 64'h0000_0100_0000_0001, "R7");
      // R9: unused codes give zero
      for (int c = 12; c < 16; c++)
         drive(4'(c), 64'hFFFF_FFFF_FFFF_FFFF, 5'd5, 64'd5, "R9");

      // deterministic sweep over all codes
      for (int i = 0; i < 400; i++) begin
         s ^= s << 13;
         s ^= s >> 7;
         s ^= s << 17;
         drive(4'(i % 16), s, s[12:8], {s[31:0], s[63:32]}, "");
      end

      repeat (3) @(posedge clk);
      #2;
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule